// File: doc/BRIEF.md
# Interlaced Component Video Word Stream Generator

This block produces the byte stream an external composite-video encoder expects for 525-line interlaced video. At the default settings, one 8-bit word leaves the block on each 27 MHz clock. Each line holds 1716 words, and the 525 lines form two fields. Line and field timing are not carried on separate sync wires. Instead, each line starts with a four-word end-of-active-video marker and its blanking filler, followed by a four-word start-of-active-video marker. The last word of each marker holds the field flag, the vertical-blanking flag, the marker-type flag and four protection bits.

The active video of a picture line is sent as 4:2:2 words in the order Cb, Y, Cr, Y. Each group of four words takes one pixel pair from an upstream source, such as a frame-buffer reader, through a ready/valid handshake. If the source has no pair ready in that cycle, the block sends black for that pair and pulses an underrun flag. The block also reports the line number and field flag of the word on its output. Every length and line boundary is a parameter.

Top module: `vidstream_gen`

## Requirements
- R1: While `rst` is high, `vid_data` is 0x80, `vid_line` is 1, `vid_field` is 0, `px_underrun` is 0 and `px_ready` is 0. After reset is released, the first word is the first word of line 1.
- R2: Each line starts with the end marker: word offsets 0 to 2 of the line are 0xFF, 0x00, 0x00.
- R3: The fourth word of each marker is {1, F, V, H, V^H, F^H, F^V, F^V^H}, from bit 7 down to bit 0. H is 1 in the end marker and 0 in the start marker.
- R4: Horizontal blanking is HBLANK_WORDS words that alternate 0x80, 0x10, starting with 0x80.
- R5: After the blanking comes the start marker: 0xFF, 0x00, 0x00, then the code word with H=0.
- R6: On picture lines, the active region sends pairs as Cb, Y0, Cr, Y1. Cb is taken from `px_cb` in the handshake cycle, and the other three come from the pair captured in that cycle.
- R7: `px_ready` is high for exactly one cycle per pair: the cycle in which the Cb word is produced on a picture line. It is never high in any other cycle. The Cb word appears on `vid_data` one clock after the handshake cycle.
- R8: If `px_valid` is low while `px_ready` is high, that pair is sent as 0x80, 0x10, 0x80, 0x10 (black). `px_underrun` is high for exactly the cycle in which the Cb word of that pair is on the output.
- R9: V is 1 on lines below ACT1_FIRST and on lines from BLK2_FIRST up to (not including) ACT2_FIRST. On such lines, the active region alternates 0x80, 0x10 and no pair is requested.
- R10: F is 1 on lines from F2_FIRST on and on lines below F1_FIRST, and 0 otherwise. `vid_field` and `vid_line` describe the line of the word on `vid_data`. `vid_line` counts from 1 to TOTAL_LINES and then returns to 1.
- R11: A line is 8 + HBLANK_WORDS + 4*ACTIVE_PAIRS words long. The defaults (268 blanking words, 360 pairs, 525 lines) give 1716 words per line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | Upstream pair available |
| px_cb | input | 8 | Blue-difference sample of the pair |
| px_y0 | input | 8 | First luma sample |
| px_cr | input | 8 | Red-difference sample |
| px_y1 | input | 8 | Second luma sample |
| px_ready | output | 1 | Pair taken this cycle |
| vid_data | output | 8 | Video word stream |
| vid_line | output | LNW | Line number of the current word |
| vid_field | output | 1 | Field flag of the current word |
| px_underrun | output | 1 | Black pair inserted (aligned to its Cb word) |

## Verification
The hardest cases are at the frame boundaries. These are where the field flag changes and where the line counter wraps from the last line back to line 1. An underrun that lands on the first or last pair of a line is also hard to reach, because at full size a frame takes 900,900 clocks. The bench therefore builds the block with a 12-line frame of 22-word lines. These settings still put vertical blanking, both field changes and the wrap inside a few hundred cycles. The bench then runs three frames with the source always valid, valid three times in four, and rarely valid, so that every pair position meets an underrun.

// File: rtl/vidstream_pkg.sv
package vidstream_pkg;

    typedef enum logic [1:0] {
        SEG_EAV    = 2'd0,
        SEG_HBLANK = 2'd1,
        SEG_SAV    = 2'd2,
        SEG_ACTIVE = 2'd3
    } seg_e;

    typedef struct packed {
        logic [7:0] cb;
        logic [7:0] y0;
        logic [7:0] cr;
        logic [7:0] y1;
    } pair_t;

    localparam logic [7:0] LUMA_BLACK   = 8'h10;
    localparam logic [7:0] CHROMA_ZERO  = 8'h80;
    localparam logic [7:0] MARK_FIRST   = 8'hFF;
    localparam logic [7:0] MARK_MIDDLE  = 8'h00;
    localparam int         MARK_WORDS   = 4;

    localparam pair_t BLACK_PAIR = '{cb: CHROMA_ZERO, y0: LUMA_BLACK,
                                     cr: CHROMA_ZERO, y1: LUMA_BLACK};

    function automatic logic [7:0] mark_code(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/vidstream_timing.sv
module vidstream_timing
    import vidstream_pkg::*;
#(
    parameter int HBLANK_WORDS = 268,
    parameter int ACTIVE_PAIRS = 360,
    parameter int TOTAL_LINES  = 525,
    parameter int F1_FIRST     = 4,
    parameter int ACT1_FIRST   = 20,
    parameter int BLK2_FIRST   = 264,
    parameter int F2_FIRST     = 266,
    parameter int ACT2_FIRST   = 283,
    localparam int LINE_WORDS  = 2 * MARK_WORDS + HBLANK_WORDS + 4 * ACTIVE_PAIRS,
    localparam int HW          = $clog2(LINE_WORDS),
    localparam int LNW         = $clog2(TOTAL_LINES + 1)
) (
    input  logic           clk,
    input  logic           rst,
    output seg_e           seg,
    output logic [1:0]     seg_idx,
    output logic [LNW-1:0] line,
    output logic           fld,
    output logic           vbl
);
    localparam logic [HW-1:0] SAV_AT  = HW'(MARK_WORDS + HBLANK_WORDS);
    localparam logic [HW-1:0] ACT_AT  = HW'(2 * MARK_WORDS + HBLANK_WORDS);
    localparam logic [HW-1:0] HBL_AT  = HW'(MARK_WORDS);
    localparam logic [HW-1:0] LAST_W  = HW'(LINE_WORDS - 1);

    logic [HW-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            line <= LNW'(1);
        end else if (hcnt == LAST_W) begin
            hcnt <= '0;
            line <= (line == LNW'(TOTAL_LINES)) ? LNW'(1) : line + LNW'(1);
        end else begin
            hcnt <= hcnt + HW'(1);
        end
    end

    always_comb begin
        if (hcnt < HBL_AT) begin
            seg     = SEG_EAV;
            seg_idx = 2'(hcnt);
        end else if (hcnt < SAV_AT) begin
            seg     = SEG_HBLANK;
            seg_idx = 2'(hcnt - HBL_AT);
        end else if (hcnt < ACT_AT) begin
            seg     = SEG_SAV;
            seg_idx = 2'(hcnt - SAV_AT);
        end else begin
            seg     = SEG_ACTIVE;
            seg_idx = 2'(hcnt - ACT_AT);
        end
    end

    assign fld = (line >= LNW'(F2_FIRST)) || (line < LNW'(F1_FIRST));
    assign vbl = (line < LNW'(ACT1_FIRST)) ||
                 ((line >= LNW'(BLK2_FIRST)) && (line < LNW'(ACT2_FIRST)));

endmodule

// File: rtl/vidstream_word.sv
module vidstream_word
    import vidstream_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seg_e       seg,
    input  logic [1:0] seg_idx,
    input  logic       fld,
    input  logic       vbl,
    input  logic       px_valid,
    input  pair_t      px_pair,
    output logic       take,
    output logic       starve,
    output logic [7:0] word
);
    pair_t held;

    assign take   = (seg == SEG_ACTIVE) && !vbl && (seg_idx == 2'd0);
    assign starve = take && !px_valid;

    always_ff @(posedge clk) begin
        if (rst)
            held <= BLACK_PAIR;
        else if (take)
            held <= px_valid ? px_pair : BLACK_PAIR;
    end

    always_comb begin
        word = CHROMA_ZERO;
        case (seg)
            SEG_EAV, SEG_SAV: begin
                case (seg_idx)
                    2'd0:    word = MARK_FIRST;
                    2'd3:    word = mark_code(fld, vbl, seg == SEG_EAV);
                    default: word = MARK_MIDDLE;
                endcase
            end
            SEG_HBLANK: word = seg_idx[0] ? LUMA_BLACK : CHROMA_ZERO;
            SEG_ACTIVE: begin
                if (vbl) begin
                    word = seg_idx[0] ? LUMA_BLACK : CHROMA_ZERO;
                end else begin
                    case (seg_idx)
                        2'd0:    word = px_valid ? px_pair.cb : CHROMA_ZERO;
                        2'd1:    word = held.y0;
                        2'd2:    word = held.cr;
                        default: word = held.y1;
                    endcase
                end
            end
            default: word = CHROMA_ZERO;
        endcase
    end

endmodule

// File: rtl/vidstream_gen.sv
module vidstream_gen
    import vidstream_pkg::*;
#(
    parameter int HBLANK_WORDS = 268,
    parameter int ACTIVE_PAIRS = 360,
    parameter int TOTAL_LINES  = 525,
    parameter int F1_FIRST     = 4,
    parameter int ACT1_FIRST   = 20,
    parameter int BLK2_FIRST   = 264,
    parameter int F2_FIRST     = 266,
    parameter int ACT2_FIRST   = 283,
    localparam int LNW         = $clog2(TOTAL_LINES + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           px_valid,
    input  logic [7:0]     px_cb,
    input  logic [7:0]     px_y0,
    input  logic [7:0]     px_cr,
    input  logic [7:0]     px_y1,
    output logic           px_ready,
    output logic [7:0]     vid_data,
    output logic [LNW-1:0] vid_line,
    output logic           vid_field,
    output logic           px_underrun
);
    seg_e           seg;
    logic [1:0]     seg_idx;
    logic [LNW-1:0] line;
    logic           fld;
    logic           vbl;
    logic           take;
    logic           starve;
    logic [7:0]     word;
    pair_t          pair_in;

    assign pair_in = '{cb: px_cb, y0: px_y0, cr: px_cr, y1: px_y1};

    vidstream_timing #(
        .HBLANK_WORDS(HBLANK_WORDS), .ACTIVE_PAIRS(ACTIVE_PAIRS),
        .TOTAL_LINES(TOTAL_LINES),   .F1_FIRST(F1_FIRST),
        .ACT1_FIRST(ACT1_FIRST),     .BLK2_FIRST(BLK2_FIRST),
        .F2_FIRST(F2_FIRST),         .ACT2_FIRST(ACT2_FIRST)
    ) timing_i (
        .clk(clk), .rst(rst), .seg(seg), .seg_idx(seg_idx),
        .line(line), .fld(fld), .vbl(vbl)
    );

    vidstream_word word_i (
        .clk(clk), .rst(rst), .seg(seg), .seg_idx(seg_idx),
        .fld(fld), .vbl(vbl), .px_valid(px_valid), .px_pair(pair_in),
        .take(take), .starve(starve), .word(word)
    );

    assign px_ready = take && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            vid_data    <= CHROMA_ZERO;
            vid_line    <= LNW'(1);
            vid_field   <= 1'b0;
            px_underrun <= 1'b0;
        end else begin
            vid_data    <= word;
            vid_line    <= line;
            vid_field   <= fld;
            px_underrun <= starve;
        end
    end

endmodule

// File: rtl/vidstream_chk.sv
module vidstream_chk #(
    parameter int TOTAL_LINES = 525,
    parameter int LNW         = 10
) (
    input logic           clk,
    input logic           rst,
    input logic           px_valid,
    input logic [7:0]     px_cb,
    input logic           px_ready,
    input logic [7:0]     vid_data,
    input logic [LNW-1:0] vid_line,
    input logic           px_underrun
);
    AST_CB_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (px_ready && px_valid) |=> (vid_data == $past(px_cb) && !px_underrun)); // R6

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        px_ready |=> !px_ready); // R7

    AST_STARVE_BLACK: assert property (@(posedge clk) disable iff (rst)
        (px_ready && !px_valid) |=> (px_underrun && vid_data == 8'h80)); // R8

    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        px_underrun |-> $past(px_ready && !px_valid)); // R8

    AST_CODE_PARITY: assert property (@(posedge clk) disable iff (rst)
        ($past(vid_data, 3) == 8'hFF && $past(vid_data, 2) == 8'h00 && $past(vid_data) == 8'h00)
        |-> (vid_data[7] &&
             vid_data[3] == (vid_data[5] ^ vid_data[4]) &&
             vid_data[2] == (vid_data[6] ^ vid_data[4]) &&
             vid_data[1] == (vid_data[6] ^ vid_data[5]) &&
             vid_data[0] == (vid_data[6] ^ vid_data[5] ^ vid_data[4]))); // R3

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (vid_line >= LNW'(1) && vid_line <= LNW'(TOTAL_LINES))); // R10

endmodule

bind vidstream_gen vidstream_chk #(.TOTAL_LINES(TOTAL_LINES), .LNW(LNW)) chk_i (
    .clk(clk), .rst(rst), .px_valid(px_valid), .px_cb(px_cb),
    .px_ready(px_ready), .vid_data(vid_data), .vid_line(vid_line),
    .px_underrun(px_underrun)
);

// File: tb/vidstream_gen_tb.sv
module vidstream_gen_tb_top;
    localparam int HB   = 6;
    localparam int AP   = 2;
    localparam int TL   = 12;
    localparam int F1F  = 2;
    localparam int A1F  = 3;
    localparam int B2F  = 6;
    localparam int F2F  = 7;
    localparam int A2F  = 8;
    localparam int LW   = 8 + HB + 4 * AP;
    localparam int LNW  = $clog2(TL + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           px_valid = 1'b0;
    logic [7:0]     px_cb = 8'h40, px_y0 = 8'h40, px_cr = 8'h40, px_y1 = 8'h40;
    logic           px_ready;
    logic [7:0]     vid_data;
    logic [LNW-1:0] vid_line;
    logic           vid_field;
    logic           px_underrun;

    always #4 clk = ~clk;

    vidstream_gen #(
        .HBLANK_WORDS(HB), .ACTIVE_PAIRS(AP), .TOTAL_LINES(TL),
        .F1_FIRST(F1F), .ACT1_FIRST(A1F), .BLK2_FIRST(B2F),
        .F2_FIRST(F2F), .ACT2_FIRST(A2F)
    ) dut_i (
        .clk(clk), .rst(rst), .px_valid(px_valid), .px_cb(px_cb),
        .px_y0(px_y0), .px_cr(px_cr), .px_y1(px_y1), .px_ready(px_ready),
        .vid_data(vid_data), .vid_line(vid_line), .vid_field(vid_field),
        .px_underrun(px_underrun)
    );

    int vectors = 0;
    int errors  = 0;
    int h  = 0;
    int ln = 1;
    int mode = 0;
    int pairs = 0;
    logic [7:0] pend[$];
    logic [7:0] exp_data = 8'h80;
    int         exp_line = 1;
    logic       exp_fld = 1'b0;
    logic       exp_und = 1'b0;
    string      exp_tag = "R1";

    function automatic logic f_of(int l);
        return (l >= F2F) || (l < F1F);
    endfunction
    function automatic logic v_of(int l);
        return (l < A1F) || (l >= B2F && l < A2F);
    endfunction
    function automatic logic [7:0] code(logic f, logic v, logic hh);
        return {1'b1, f, v, hh, v ^ hh, f ^ hh, f ^ v, f ^ v ^ hh};
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s line %0d word %0d: actual %0h expected %0h", tag, ln, h, act, exp);
        end
    endtask

    task automatic step_model();
        logic f, v, rdy;
        int s;
        f = f_of(ln);
        v = v_of(ln);
        case (mode)
            0: px_valid = 1'b1;
            1: px_valid = ($urandom % 4) != 0;
            default: px_valid = ($urandom % 5) == 0;
        endcase
        px_cb = 8'h20 + 8'((pairs * 7) % 160);
        px_y0 = 8'h30 + 8'((pairs * 5) % 150);
        px_cr = 8'h28 + 8'((pairs * 11) % 170);
        px_y1 = 8'h18 + 8'((pairs * 3) % 190);
        #1;
        rdy = (h >= 8 + HB) && !v && (((h - 8 - HB) % 4) == 0);
        check("R7", px_ready, rdy);
        exp_line = ln;
        exp_fld  = f;
        exp_und  = 1'b0;
        if (h < 4) begin
            exp_tag  = (h == 3) ? "R3" : "R2";
            exp_data = (h == 0) ? 8'hFF : (h == 3) ? code(f, v, 1'b1) : 8'h00;
        end else if (h < 4 + HB) begin
            exp_tag  = "R4";
            exp_data = ((h - 4) % 2) ? 8'h10 : 8'h80;
        end else if (h < 8 + HB) begin
            s = h - 4 - HB;
            exp_tag  = (s == 3) ? "R3" : "R5";
            exp_data = (s == 0) ? 8'hFF : (s == 3) ? code(f, v, 1'b0) : 8'h00;
        end else if (v) begin
            exp_tag  = "R9";
            exp_data = ((h - 8 - HB) % 2) ? 8'h10 : 8'h80;
        end else if (rdy) begin
            pairs++;
            if (px_valid) begin
                exp_tag  = "R6";
                exp_data = px_cb;
                pend.push_back(px_y0); pend.push_back(px_cr); pend.push_back(px_y1);
            end else begin
                exp_tag  = "R8";
                exp_data = 8'h80;
                exp_und  = 1'b1;
                pend.push_back(8'h10); pend.push_back(8'h80); pend.push_back(8'h10);
            end
        end else begin
            exp_tag  = "R6";
            exp_data = pend.pop_front();
        end
        h++;
        if (h == LW) begin
            h  = 0;
            ln = (ln == TL) ? 1 : ln + 1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", vid_data, 8'h80);
        check("R1", vid_line, 1);
        check("R1", vid_field, 0);
        check("R1", px_underrun, 0);
        check("R1", px_ready, 0);
        rst = 1'b0;
        step_model();
        for (int c = 0; c < 3 * LW * TL; c++) begin
            @(negedge clk);
            check(exp_tag, vid_data, exp_data);
            check("R8", px_underrun, exp_und);
            check("R10,R11", vid_line, exp_line);
            check("R10", vid_field, exp_fld);
            mode = c / (LW * TL);
            step_model();
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule